// File: doc/BRIEF.md
# Three-Port Address Lookup Engine

This block makes the forwarding decision for a small three-port Ethernet switch. Port 0 faces the local host and ports 1 and 2 face the external links. For each received frame the caller presents the ingress port, the destination MAC address, a directed-egress code and a CRC-present flag. One cycle after the request is accepted, the block returns a three-bit egress mask in which bit *n* selects port *n*.

Software programs the block through a word-addressed register interface. There is a global control word, a forwarding-state word for each port, and a table window. The table window is three data words plus a table command word, and it reads and writes entries of a 16-entry unicast table indirectly.

In normal mode the destination is matched against every valid unicast entry. A hit goes to the owning port, and a miss or a broadcast floods. In bypass mode the table is ignored: external traffic goes to the host, and host traffic leaves on the port named by its directed-egress code.

Top module: `addr_lookup_engine`

## Requirements
- R1: After reset, `rsp_valid` is 0, `lk_ready` is 1, and the global control and port control registers read as zero.
- R2: While global control bit 31 (engine enable) is 0, every accepted lookup returns mask 000.
- R3: A port takes part in forwarding only while bits 1:0 of its port control register equal 3. A frame from a port in any other state gets mask 000, and a port in any other state is never set in a mask.
- R4: With global control bit 4 (bypass) set, a frame from port 1 or port 2 gets mask 001 whatever the table holds.
- R5: In bypass mode a frame from port 0 gets mask 010 for directed code 1, mask 100 for code 2, and mask 000 for codes 0 and 3. In every mode `rsp_crc` echoes the `lk_crc` of the request.
- R6: A write of the table command register (address 4) with bit 31 set stores the entry at the index in bits 3:0, taking the entry from the data words. Data word 0 (address 5) holds MAC bits 31:0. Data word 1 (address 6) holds MAC bits 47:32 in bits 15:0 and the entry type in bits 29:28. Data word 2 (address 7) holds the owning port in bits 3:2. The store happens one cycle later, and `lk_ready` is 0 during that cycle.
- R7: A write of the table command register with bit 31 clear loads the indexed entry into the three data words, using the same layout as R6. Register reads return data one cycle after the address is presented.
- R8: In normal mode, a destination that matches an entry of type 1 goes only to that entry's port. The mask is 000 if that port is the ingress port or is not forwarding. Entries of any other type never match.
- R9: In normal mode, a broadcast destination (all ones) or a table miss floods to every forwarding port except the ingress port.
- R10: Writing global control with bit 30 set clears the table one entry per cycle. `lk_ready` stays 0 and bit 30 reads back as 1 for the 16 cycles of the clear. Afterwards every entry reads back as zero.
- R11: `rsp_valid` is 1 in exactly the cycle after a request is accepted (`lk_valid` and `lk_ready` both high), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the address |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted (no table write or clear pending) |
| lk_port | input | 2 | Ingress port of the frame |
| lk_dmac | input | 48 | Destination MAC address |
| lk_dir | input | 2 | Directed-egress code for host frames |
| lk_crc | input | 1 | Frame already carries its CRC |
| rsp_valid | output | 1 | Decision valid |
| rsp_mask | output | 3 | Egress port mask |
| rsp_crc | output | 1 | Echoed CRC-present flag |

## Verification
The checker tests some properties on every cycle:
- the one-cycle response timing,
- the echo of the CRC flag,
- that no frame is ever reflected to its ingress port,
- the all-zero mask while disabled,
- that bypass never sends external traffic anywhere but the host,
- that the ready line is held low while a table write or clear is pending.

Only the bench scenarios can show the rest. These are the exact hit, flood and directed masks for known table contents, the bit layout of entries seen through readback, the effect of non-forwarding port states, and that a clear really empties the table.

// File: rtl/lk_pkg.sv
`timescale 1ns/1ps
package lk_pkg;
  localparam int MAC_W   = 48;
  localparam int NPORT   = 3;
  localparam int WORD_W  = 32;

  localparam logic [2:0] A_GCTL  = 3'd0;
  localparam logic [2:0] A_PCTL0 = 3'd1;
  localparam logic [2:0] A_PCTL1 = 3'd2;
  localparam logic [2:0] A_PCTL2 = 3'd3;
  localparam logic [2:0] A_TCMD  = 3'd4;
  localparam logic [2:0] A_DW0   = 3'd5;
  localparam logic [2:0] A_DW1   = 3'd6;
  localparam logic [2:0] A_DW2   = 3'd7;

  localparam int B_EN     = 31;
  localparam int B_CLR    = 30;
  localparam int B_BYP    = 4;
  localparam int B_TWR    = 31;

  localparam logic [1:0] ST_FWD  = 2'd3;
  localparam logic [1:0] TY_UCAST = 2'd1;

  typedef struct packed {
    logic [1:0]       typ;
    logic [1:0]       port;
    logic [MAC_W-1:0] mac;
  } entry_t;
endpackage

// File: rtl/lk_regs.sv
`timescale 1ns/1ps
module lk_regs
  import lk_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  input  entry_t            rd_entry,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output entry_t            wr_entry,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              eng_en,
  output logic              bypass,
  output logic [NPORT-1:0]  port_fwd,
  output logic              tbl_busy
);
  logic [1:0]        pst [NPORT];
  logic [WORD_W-1:0] dw0, dw1, dw2;
  logic [IDX_W-1:0]  tidx;
  logic              wr_pend;
  logic              clr_act;
  logic [IDX_W-1:0]  clr_cnt;
  logic              we_tcmd;

  assign we_tcmd = cfg_we && (cfg_addr == A_TCMD);
  assign rd_idx  = cfg_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_en  <= 1'b0;
      bypass  <= 1'b0;
      clr_act <= 1'b0;
      clr_cnt <= '0;
    end else begin
      if (clr_act) begin
        if (clr_cnt == IDX_W'(NUM_ENTRIES-1)) clr_act <= 1'b0;
        clr_cnt <= clr_cnt + 1'b1;
      end
      if (cfg_we && cfg_addr == A_GCTL) begin
        eng_en <= cfg_wdata[B_EN];
        bypass <= cfg_wdata[B_BYP];
        if (cfg_wdata[B_CLR] && !clr_act) begin
          clr_act <= 1'b1;
          clr_cnt <= '0;
        end
      end
    end
  end

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) pst[p] <= 2'd0;
        else if (cfg_we && cfg_addr == 3'(A_PCTL0 + p)) pst[p] <= cfg_wdata[1:0];
      end
      assign port_fwd[p] = (pst[p] == ST_FWD);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dw0 <= '0; dw1 <= '0; dw2 <= '0;
      tidx <= '0; wr_pend <= 1'b0;
    end else begin
      wr_pend <= 1'b0;
      if (cfg_we && cfg_addr == A_DW0) dw0 <= cfg_wdata;
      if (cfg_we && cfg_addr == A_DW1) dw1 <= cfg_wdata;
      if (cfg_we && cfg_addr == A_DW2) dw2 <= cfg_wdata;
      if (we_tcmd) begin
        tidx <= rd_idx;
        if (cfg_wdata[B_TWR]) begin
          wr_pend <= 1'b1;
        end else begin
          dw0 <= rd_entry.mac[31:0];
          dw1 <= {2'b00, rd_entry.typ, 12'd0, rd_entry.mac[MAC_W-1:32]};
          dw2 <= {28'd0, rd_entry.port, 2'b00};
        end
      end
    end
  end

  assign wr_en         = wr_pend;
  assign wr_idx        = tidx;
  assign wr_entry.typ  = dw1[29:28];
  assign wr_entry.port = dw2[3:2];
  assign wr_entry.mac  = {dw1[15:0], dw0};
  assign clr_en        = clr_act;
  assign clr_idx       = clr_cnt;
  assign tbl_busy      = wr_pend | clr_act;

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_addr)
        A_GCTL:  cfg_rdata <= {eng_en, clr_act, 25'd0, bypass, 4'd0};
        A_PCTL0: cfg_rdata <= {30'd0, pst[0]};
        A_PCTL1: cfg_rdata <= {30'd0, pst[1]};
        A_PCTL2: cfg_rdata <= {30'd0, pst[2]};
        A_TCMD:  cfg_rdata <= {{(WORD_W-IDX_W){1'b0}}, tidx};
        A_DW0:   cfg_rdata <= dw0;
        A_DW1:   cfg_rdata <= dw1;
        default: cfg_rdata <= dw2;
      endcase
    end
  end
endmodule

// File: rtl/lk_table.sv
`timescale 1ns/1ps
module lk_table
  import lk_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output entry_t           rd_entry,
  input  logic [MAC_W-1:0] lk_mac,
  output logic             hit,
  output logic [1:0]       hit_port
);
  entry_t                 mem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] match;

  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) mem[i] <= '0;
        else if (clr_en && clr_idx == IDX_W'(i)) mem[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i)) mem[i] <= wr_entry;
      end
      assign match[i] = (mem[i].typ == TY_UCAST) && (mem[i].mac == lk_mac);
    end
  endgenerate

  assign rd_entry = mem[rd_idx];

  always_comb begin
    hit      = 1'b0;
    hit_port = 2'd0;
    for (int i = NUM_ENTRIES-1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        hit_port = mem[i].port;
      end
    end
  end
endmodule

// File: rtl/lk_decide.sv
`timescale 1ns/1ps
module lk_decide
  import lk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [1:0]       lk_port,
  input  logic [MAC_W-1:0] lk_mac,
  input  logic [1:0]       lk_dir,
  input  logic             lk_crc,
  input  logic             eng_en,
  input  logic             bypass,
  input  logic [NPORT-1:0] port_fwd,
  input  logic             hit,
  input  logic [1:0]       hit_port,
  output logic             rsp_valid,
  output logic [NPORT-1:0] rsp_mask,
  output logic             rsp_crc
);
  logic [3:0]       fwd4;
  logic [NPORT-1:0] ing, hitm, nxt;
  logic             in_ok, bcast;

  assign fwd4  = {1'b0, port_fwd};
  assign in_ok = fwd4[lk_port];
  assign ing   = NPORT'(3'b001 << lk_port);
  assign hitm  = NPORT'(3'b001 << hit_port);
  assign bcast = &lk_mac;

  always_comb begin
    nxt = '0;
    if (eng_en && in_ok) begin
      if (bypass) begin
        if (lk_port != 2'd0) nxt = 3'b001 & port_fwd;
        else begin
          case (lk_dir)
            2'd1:    nxt = 3'b010 & port_fwd;
            2'd2:    nxt = 3'b100 & port_fwd;
            default: nxt = '0;
          endcase
        end
      end else if (hit && !bcast) begin
        nxt = hitm & port_fwd & ~ing;
      end else begin
        nxt = port_fwd & ~ing;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_mask  <= '0;
      rsp_crc   <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_mask <= nxt;
        rsp_crc  <= lk_crc;
      end
    end
  end
endmodule

// File: rtl/addr_lookup_engine.sv
`timescale 1ns/1ps
module addr_lookup_engine
  import lk_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [1:0]  lk_port,
  input  logic [47:0] lk_dmac,
  input  logic [1:0]  lk_dir,
  input  logic        lk_crc,
  output logic        rsp_valid,
  output logic [2:0]  rsp_mask,
  output logic        rsp_crc
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [IDX_W-1:0] rd_idx, wr_idx, clr_idx;
  entry_t           rd_entry, wr_entry;
  logic             wr_en, clr_en, eng_en, bypass, tbl_busy, hit, acc;
  logic [1:0]       hit_port;
  logic [NPORT-1:0] port_fwd;

  assign lk_ready = !tbl_busy;
  assign acc      = lk_valid && lk_ready;

  lk_regs #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_idx(rd_idx), .rd_entry(rd_entry),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .eng_en(eng_en), .bypass(bypass), .port_fwd(port_fwd), .tbl_busy(tbl_busy)
  );

  lk_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .clr_en(clr_en), .clr_idx(clr_idx), .rd_idx(rd_idx), .rd_entry(rd_entry),
    .lk_mac(lk_dmac), .hit(hit), .hit_port(hit_port)
  );

  lk_decide u_decide (
    .clk(clk), .rst(rst), .acc(acc), .lk_port(lk_port), .lk_mac(lk_dmac),
    .lk_dir(lk_dir), .lk_crc(lk_crc), .eng_en(eng_en), .bypass(bypass),
    .port_fwd(port_fwd), .hit(hit), .hit_port(hit_port),
    .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_crc(rsp_crc)
  );
endmodule

// File: rtl/lk_checker.sv
`timescale 1ns/1ps
module lk_checker (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [2:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [1:0]  lk_port,
  input logic        lk_crc,
  input logic        rsp_valid,
  input logic [2:0]  rsp_mask,
  input logic        rsp_crc,
  input logic        eng_en,
  input logic        bypass,
  input logic        clr_en
);
  logic acc;
  assign acc = lk_valid && lk_ready;

  p_resp_on_accept_r11: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);
  p_no_resp_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid);
  p_crc_echo_r5: assert property (@(posedge clk) disable iff (rst)
    acc |=> (rsp_crc == $past(lk_crc)));
  p_disabled_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && !eng_en) |=> (rsp_mask == 3'b000));
  p_no_reflect_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && lk_port != 2'd3) |=> ((rsp_mask & (3'b001 << $past(lk_port))) == 3'b000));
  p_bypass_host_only_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && eng_en && bypass && lk_port != 2'd0) |=> ((rsp_mask & 3'b110) == 3'b000));
  p_write_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 3'd4 && cfg_wdata[31]) |=> !lk_ready);
  p_clear_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> !lk_ready);
endmodule

bind addr_lookup_engine lk_checker u_lk_checker (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_port(lk_port), .lk_crc(lk_crc),
  .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_crc(rsp_crc),
  .eng_en(eng_en), .bypass(bypass), .clr_en(clr_en)
);

// File: tb/test_addr_lookup_engine.sv
`timescale 1ns/1ps
module test_addr_lookup_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [1:0]  lk_port = 2'd0;
  logic [47:0] lk_dmac = 48'd0;
  logic [1:0]  lk_dir = 2'd0;
  logic        lk_crc = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_mask;
  logic        rsp_crc;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  addr_lookup_engine i_addr_lookup_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_port(lk_port),
    .lk_dmac(lk_dmac), .lk_dir(lk_dir), .lk_crc(lk_crc),
    .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_crc(rsp_crc)
  );

  localparam logic [47:0] MA = 48'h0211_2233_4455;
  localparam logic [47:0] MB = 48'h0266_7788_99aa;
  localparam logic [47:0] MC = 48'h0200_0000_0001;
  localparam logic [47:0] MD = 48'h0233_0000_beef;
  localparam logic [47:0] MU = 48'h0aaa_bbbb_cccc;
  localparam logic [47:0] BC = 48'hffff_ffff_ffff;

  // {bypass, port, dmac, dir, crc, expected mask}
  localparam int NV = 17;
  localparam logic [56:0] VECS [NV] = '{
    {1'b0, 2'd0, MA, 2'd0, 1'b0, 3'b010},
    {1'b0, 2'd0, MB, 2'd0, 1'b1, 3'b100},
    {1'b0, 2'd1, MB, 2'd0, 1'b0, 3'b100},
    {1'b0, 2'd2, MA, 2'd0, 1'b0, 3'b010},
    {1'b0, 2'd1, MA, 2'd0, 1'b0, 3'b000},
    {1'b0, 2'd1, MC, 2'd0, 1'b0, 3'b001},
    {1'b0, 2'd0, MC, 2'd0, 1'b0, 3'b000},
    {1'b0, 2'd0, MU, 2'd0, 1'b0, 3'b110},
    {1'b0, 2'd1, BC, 2'd0, 1'b0, 3'b101},
    {1'b0, 2'd2, MU, 2'd0, 1'b1, 3'b011},
    {1'b0, 2'd3, MA, 2'd0, 1'b0, 3'b000},
    {1'b1, 2'd1, MA, 2'd0, 1'b0, 3'b001},
    {1'b1, 2'd2, MU, 2'd0, 1'b1, 3'b001},
    {1'b1, 2'd0, MA, 2'd1, 1'b0, 3'b010},
    {1'b1, 2'd0, MU, 2'd2, 1'b1, 3'b100},
    {1'b1, 2'd0, MB, 2'd0, 1'b0, 3'b000},
    {1'b1, 2'd0, MB, 2'd3, 1'b0, 3'b000}
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic put_entry(input int idx, input logic [47:0] mac,
                           input logic [1:0] typ, input logic [1:0] port);
    wr(3'd5, mac[31:0]);
    wr(3'd6, {2'b00, typ, 12'd0, mac[47:32]});
    wr(3'd7, {28'd0, port, 2'b00});
    wr(3'd4, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic look(input logic [1:0] p, input logic [47:0] mac, input logic [1:0] dir,
                      input logic crc, output logic v, output logic [2:0] m, output logic c);
    @(negedge clk);
    lk_valid = 1'b1; lk_port = p; lk_dmac = mac; lk_dir = dir; lk_crc = crc;
    @(negedge clk);
    v = rsp_valid; m = rsp_mask; c = rsp_crc;
    lk_valid = 1'b0;
  endtask

  task automatic look_chk(input string req, input logic [1:0] p, input logic [47:0] mac,
                          input logic [2:0] exp);
    logic v, c;
    logic [2:0] m;
    look(p, mac, 2'd0, 1'b0, v, m, c);
    check(req, {47'd0, v}, 48'd1);
    check(req, {45'd0, m}, {45'd0, exp});
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v, c;
    logic [2:0] m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", {47'd0, rsp_valid}, 48'd0);
    check("R1 lk_ready", {47'd0, lk_ready}, 48'd1);
    rd(3'd0, d); check("R1 gctl", {16'd0, d}, 48'd0);
    rd(3'd3, d); check("R1 pctl2", {16'd0, d}, 48'd0);

    wr(3'd0, 32'h8000_0000);
    wr(3'd1, 32'd3); wr(3'd2, 32'd3); wr(3'd3, 32'd3);
    put_entry(0, MA, 2'd1, 2'd1);
    put_entry(1, MB, 2'd1, 2'd2);
    put_entry(2, MC, 2'd1, 2'd0);
    // R6: store blocks lookups for exactly one cycle
    wr(3'd5, MD[31:0]); wr(3'd6, {2'b00, 2'd2, 12'd0, MD[47:32]}); wr(3'd7, 32'h4);
    wr(3'd4, 32'h8000_0003);
    check("R6 ready low after store", {47'd0, lk_ready}, 48'd0);
    @(negedge clk);
    check("R6 ready back", {47'd0, lk_ready}, 48'd1);

    // R7: readback of entry 1
    wr(3'd4, 32'h0000_0001);
    rd(3'd5, d); check("R7 dw0", {16'd0, d}, {16'd0, 32'h7788_99aa});
    rd(3'd6, d); check("R7 dw1", {16'd0, d}, {16'd0, 32'h1000_0266});
    rd(3'd7, d); check("R7 dw2", {16'd0, d}, {16'd0, 32'h0000_0008});

    // vector table: R4 R5 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [56:0] vec;
      string tag;
      vec = VECS[i];
      wr(3'd0, 32'h8000_0000 | (32'(vec[56]) << 4));
      look(vec[55:54], vec[53:6], vec[5:4], vec[3], v, m, c);
      tag = vec[56] ? ((vec[55:54] == 2'd0) ? "R5 vec" : "R4 vec") : "R8 R9 vec";
      check("R11 valid", {47'd0, v}, 48'd1);
      check(tag, {45'd0, m}, {45'd0, vec[2:0]});
      check("R5 crc echo", {47'd0, c}, {47'd0, vec[3]});
    end
    wr(3'd0, 32'h8000_0000);
    @(negedge clk);
    check("R11 idle", {47'd0, rsp_valid}, 48'd0);

    // R8: entry of non-unicast type never matches
    look_chk("R8 type2 ignored", 2'd2, MD, 3'b011);

    // R3: port 2 not forwarding
    wr(3'd3, 32'd2);
    look_chk("R3 hit to blocked", 2'd0, MB, 3'b000);
    look_chk("R3 flood skips blocked", 2'd0, MU, 3'b010);
    look_chk("R3 blocked ingress", 2'd2, MA, 3'b000);
    wr(3'd3, 32'd3);

    // R2: disabled
    wr(3'd0, 32'h0000_0000);
    look_chk("R2 disabled", 2'd0, MU, 3'b000);
    wr(3'd0, 32'h8000_0000);

    // R10: table clear
    wr(3'd0, 32'hC000_0000);
    check("R10 ready low", {47'd0, lk_ready}, 48'd0);
    rd(3'd0, d); check("R10 clear bit", {47'd0, d[30]}, 48'd1);
    repeat (16) @(negedge clk);
    check("R10 ready back", {47'd0, lk_ready}, 48'd1);
    wr(3'd4, 32'h0000_0000);
    rd(3'd5, d); check("R10 dw0 zero", {16'd0, d}, 48'd0);
    rd(3'd6, d); check("R10 dw1 zero", {16'd0, d}, 48'd0);
    look_chk("R10 cleared floods", 2'd1, MA, 3'b101);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule